// File: doc/BRIEF.md
# FEC Alignment Reference Lane Calculator

This block turns the per-lane alignment measurements of a four-lane receive path with Reed-Solomon forward error correction into the timing values that a precision time-stamping unit needs. It first finds which physical lane carries FEC lane 0 by scanning the lane-mapping fields. It then expresses each lane's alignment-marker arrival as an offset from that lane, using the skew difference in 80-UI blocks plus the low five bits of the codeword position, all scaled by the UI value.

The lane with the smallest skew becomes the reference lane. Its sign-magnitude pulse offset, its wire delay and its sync offset are combined with the sign-magnitude constant delay to form the adjust value. The extra latency then subtracts the PMA delay (given in UI and scaled to time) and the external PHY delay from the adjust value. All values share one time unit and are handled as two's-complement numbers of `RES_W` bits, a width chosen so that no result overflows. A caller presents a full measurement set with `valid_i` for one cycle and reads the results on the next cycle, when `valid_o` is high.

Top module: `fec_ref_lane_calc`

## Requirements
- R1: The lane-0 index output is the lowest physical lane whose mapping field (7 bits, lane n at bits [7n+6:7n] of `lane_map_i`) equals 0.
- R2: If no mapping field equals 0, `lane0_err_o` is 1 and the lane-0 index output is 0. Otherwise `lane0_err_o` is 0.
- R3: For every lane p, sync offset p equals ((skew[lane0] − skew[p])·80 + cw_pos[4:0])·UI. The skews are unsigned 7-bit fields, lane n at bits [7n+6:7n]. Bits [14:5] of the codeword position have no effect.
- R4: The reference lane is the lane with the smallest skew. When several lanes share the minimum, the lowest index wins.
- R5: A sign-magnitude input (32 bits, bit 31 = sign, bits [30:0] = magnitude) counts as −magnitude when the sign is 1 and +magnitude otherwise. A negative zero counts as 0.
- R6: adjust = const_delay + pulse_offset[ref] − wire_delay[ref] + sync_offset[ref]. The wire delays are unsigned 20-bit fields, lane n at bits [20n+19:20n].
- R7: extra_latency = −(pma_delay_ui·UI) − external_phy_delay + adjust. The external PHY delay is a signed 32-bit value, and the PMA delay and UI are unsigned.
- R8: Results are captured on a clock edge where `valid_i` is 1. `valid_o` is 1 in exactly the cycle after such an edge. While `valid_i` is 0, all result outputs hold their values.
- R9: After reset, `valid_o`, the lane indices, the error flag and all result values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Measurement set is present; capture the results |
| lane_map_i | input | LANES*MAP_W | FEC lane number per physical lane |
| lane_skew_i | input | LANES*SKEW_W | FEC skew per physical lane |
| cw_pos_i | input | CW_W | Codeword position of FEC lane 0 |
| const_dly_i | input | SM_W | Constant delay, sign-magnitude |
| pulse_off_i | input | LANES*SM_W | Async pulse offset per lane, sign-magnitude |
| wire_dly_i | input | LANES*WDLY_W | Wire delay per lane, unsigned |
| pma_dly_i | input | PMA_W | PMA delay in UI, unsigned |
| ext_dly_i | input | EXT_W | External PHY delay, signed |
| ui_i | input | UI_W | UI duration in time units, unsigned |
| valid_o | output | 1 | Results updated in the previous cycle |
| ref_lane_o | output | IDX_W | Reference physical lane |
| lane0_lane_o | output | IDX_W | Physical lane carrying FEC lane 0 |
| lane0_err_o | output | 1 | No lane maps to FEC lane 0 |
| sync_off_o | output | LANES*RES_W | Signed sync offset per lane |
| adjust_o | output | RES_W | Signed timing-adjust value |
| extra_lat_o | output | RES_W | Signed extra latency |

## Verification
The bench applies a series of lane-mapping patterns: rotations and reversals of a permutation, which move FEC lane 0 to every physical lane; sets that hold no zero field; and sets that hold two zero fields. Together these tell correct lane-0 detection apart from a fixed or last-match choice. Skew sets that are all equal, or that have a duplicated minimum in the upper lanes, tell lowest-index tie breaking apart from highest-index. Extreme skews, a full-scale UI and a full-scale PMA delay, together with sign-magnitude values that include negative zero and codeword positions whose upper bits are set, expose sign, width and masking errors in the sync, adjust and extra-latency arithmetic. A hold step after each capture shows that changed inputs without `valid_i` leave the results untouched.

// File: rtl/fec_ref_pkg.sv
package fec_ref_pkg;
  localparam int unsigned AM_BLOCK_UI = 80;
  localparam int unsigned CW_LOW_W    = 5;
endpackage

// File: rtl/fec_lane0_find.sv
module fec_lane0_find #(
  parameter int LANES = 4,
  parameter int MAP_W = 7,
  parameter int IDX_W = 2
) (
  input  logic [LANES*MAP_W-1:0] map_i,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   none_o
);
  always_comb begin
    idx_o  = '0;
    none_o = 1'b1;
    // scan downward so the lowest matching lane is the last to win
    for (int l = LANES - 1; l >= 0; l--) begin
      if (map_i[l*MAP_W +: MAP_W] == '0) begin
        idx_o  = IDX_W'(l);
        none_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fec_min_skew.sv
module fec_min_skew #(
  parameter int LANES  = 4,
  parameter int SKEW_W = 7,
  parameter int IDX_W  = 2
) (
  input  logic [LANES*SKEW_W-1:0] skew_i,
  output logic [IDX_W-1:0]        idx_o
);
  logic [SKEW_W-1:0] best;

  always_comb begin
    idx_o = '0;
    best  = skew_i[SKEW_W-1:0];
    for (int l = 1; l < LANES; l++) begin
      // strict compare keeps the lower index on ties
      if (skew_i[l*SKEW_W +: SKEW_W] < best) begin
        best  = skew_i[l*SKEW_W +: SKEW_W];
        idx_o = IDX_W'(l);
      end
    end
  end
endmodule

// File: rtl/fec_sm_conv.sv
module fec_sm_conv #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 48
) (
  input  logic [IN_W-1:0]         sm_i,
  output logic signed [OUT_W-1:0] val_o
);
  logic signed [OUT_W-1:0] mag;

  always_comb begin
    mag   = $signed(OUT_W'(sm_i[IN_W-2:0]));
    val_o = sm_i[IN_W-1] ? -mag : mag;
  end
endmodule

// File: rtl/fec_sync_off.sv
module fec_sync_off
  import fec_ref_pkg::*;
#(
  parameter int SKEW_W = 7,
  parameter int UI_W   = 24,
  parameter int RES_W  = 48
) (
  input  logic [SKEW_W-1:0]       skew_ref_i,
  input  logic [SKEW_W-1:0]       skew_i,
  input  logic [CW_LOW_W-1:0]     cw_low_i,
  input  logic [UI_W-1:0]         ui_i,
  output logic signed [RES_W-1:0] sync_o
);
  logic signed [RES_W-1:0] diff, blk;

  always_comb begin
    diff   = $signed(RES_W'(skew_ref_i)) - $signed(RES_W'(skew_i));
    blk    = diff * $signed(RES_W'(AM_BLOCK_UI)) + $signed(RES_W'(cw_low_i));
    sync_o = blk * $signed(RES_W'(ui_i));
  end
endmodule

// File: rtl/fec_ref_lane_calc.sv
module fec_ref_lane_calc
  import fec_ref_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int MAP_W  = 7,
  parameter int SKEW_W = 7,
  parameter int CW_W   = 15,
  parameter int SM_W   = 32,
  parameter int WDLY_W = 20,
  parameter int PMA_W  = 16,
  parameter int UI_W   = 24,
  parameter int EXT_W  = 32,
  parameter int RES_W  = 48,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [LANES*MAP_W-1:0] lane_map_i,
  input  logic [LANES*SKEW_W-1:0] lane_skew_i,
  input  logic [CW_W-1:0]        cw_pos_i,
  input  logic [SM_W-1:0]        const_dly_i,
  input  logic [LANES*SM_W-1:0]  pulse_off_i,
  input  logic [LANES*WDLY_W-1:0] wire_dly_i,
  input  logic [PMA_W-1:0]       pma_dly_i,
  input  logic [EXT_W-1:0]       ext_dly_i,
  input  logic [UI_W-1:0]        ui_i,
  output logic                   valid_o,
  output logic [IDX_W-1:0]       ref_lane_o,
  output logic [IDX_W-1:0]       lane0_lane_o,
  output logic                   lane0_err_o,
  output logic [LANES*RES_W-1:0] sync_off_o,
  output logic [RES_W-1:0]       adjust_o,
  output logic [RES_W-1:0]       extra_lat_o
);
  logic [IDX_W-1:0] lane0_idx, ref_idx;
  logic             no_lane0;
  logic [SKEW_W-1:0] skew_a [LANES];
  logic [SKEW_W-1:0] skew0;
  logic signed [RES_W-1:0] sync_a [LANES];
  logic signed [RES_W-1:0] poff_a [LANES];
  logic signed [RES_W-1:0] wdly_a [LANES];
  logic signed [RES_W-1:0] const_s, ext_s, pma_t, adjust, extra;
  logic signed [RES_W-1:0] sync_q [LANES];

  fec_lane0_find #(.LANES(LANES), .MAP_W(MAP_W), .IDX_W(IDX_W)) u_find (
    .map_i (lane_map_i),
    .idx_o (lane0_idx),
    .none_o(no_lane0)
  );

  fec_min_skew #(.LANES(LANES), .SKEW_W(SKEW_W), .IDX_W(IDX_W)) u_min (
    .skew_i(lane_skew_i),
    .idx_o (ref_idx)
  );

  fec_sm_conv #(.IN_W(SM_W), .OUT_W(RES_W)) u_const (
    .sm_i (const_dly_i),
    .val_o(const_s)
  );

  assign skew0 = skew_a[lane0_idx];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign skew_a[g] = lane_skew_i[g*SKEW_W +: SKEW_W];
    assign wdly_a[g] = $signed(RES_W'(wire_dly_i[g*WDLY_W +: WDLY_W]));

    fec_sync_off #(.SKEW_W(SKEW_W), .UI_W(UI_W), .RES_W(RES_W)) u_sync (
      .skew_ref_i(skew0),
      .skew_i    (skew_a[g]),
      .cw_low_i  (cw_pos_i[CW_LOW_W-1:0]),
      .ui_i      (ui_i),
      .sync_o    (sync_a[g])
    );

    fec_sm_conv #(.IN_W(SM_W), .OUT_W(RES_W)) u_poff (
      .sm_i (pulse_off_i[g*SM_W +: SM_W]),
      .val_o(poff_a[g])
    );

    assign sync_off_o[g*RES_W +: RES_W] = sync_q[g];
  end

  always_comb begin
    ext_s  = {{(RES_W-EXT_W){ext_dly_i[EXT_W-1]}}, ext_dly_i};
    pma_t  = $signed(RES_W'(pma_dly_i)) * $signed(RES_W'(ui_i));
    adjust = const_s + poff_a[ref_idx] - wdly_a[ref_idx] + sync_a[ref_idx];
    extra  = adjust - pma_t - ext_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      ref_lane_o   <= '0;
      lane0_lane_o <= '0;
      lane0_err_o  <= 1'b0;
      adjust_o     <= '0;
      extra_lat_o  <= '0;
      for (int l = 0; l < LANES; l++) sync_q[l] <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ref_lane_o   <= ref_idx;
        lane0_lane_o <= lane0_idx;
        lane0_err_o  <= no_lane0;
        adjust_o     <= adjust;
        extra_lat_o  <= extra;
        for (int l = 0; l < LANES; l++) sync_q[l] <= sync_a[l];
      end
    end
  end
endmodule

// File: rtl/fec_ref_lane_calc_chk.sv
module fec_ref_lane_calc_chk #(
  parameter int LANES  = 4,
  parameter int MAP_W  = 7,
  parameter int SKEW_W = 7,
  parameter int CW_W   = 15,
  parameter int UI_W   = 24,
  parameter int RES_W  = 48,
  parameter int IDX_W  = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [LANES*MAP_W-1:0]  lane_map_i,
  input logic [LANES*SKEW_W-1:0] lane_skew_i,
  input logic [CW_W-1:0]         cw_pos_i,
  input logic [UI_W-1:0]         ui_i,
  input logic                    valid_o,
  input logic [IDX_W-1:0]        ref_lane_o,
  input logic [IDX_W-1:0]        lane0_lane_o,
  input logic                    lane0_err_o,
  input logic [LANES*RES_W-1:0]  sync_off_o,
  input logic [RES_W-1:0]        adjust_o,
  input logic [RES_W-1:0]        extra_lat_o
);
  logic [LANES*MAP_W-1:0]  map_q;
  logic [LANES*SKEW_W-1:0] skew_q;
  logic [CW_W-1:0]         cw_q;
  logic [UI_W-1:0]         ui_q;
  logic any_zero, lane0_first, min_ok, tie_ok;
  logic [RES_W-1:0] sync_l0_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0; skew_q <= '0; cw_q <= '0; ui_q <= '0;
    end else if (valid_i) begin
      map_q <= lane_map_i; skew_q <= lane_skew_i; cw_q <= cw_pos_i; ui_q <= ui_i;
    end
  end

  always_comb begin
    any_zero    = 1'b0;
    lane0_first = 1'b1;
    min_ok      = 1'b1;
    tie_ok      = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (map_q[l*MAP_W +: MAP_W] == '0) begin
        any_zero = 1'b1;
        if (l < int'(lane0_lane_o)) lane0_first = 1'b0;
      end
      if (skew_q[l*SKEW_W +: SKEW_W] < skew_q[ref_lane_o*SKEW_W +: SKEW_W]) min_ok = 1'b0;
      if (l < int'(ref_lane_o) &&
          skew_q[l*SKEW_W +: SKEW_W] == skew_q[ref_lane_o*SKEW_W +: SKEW_W]) tie_ok = 1'b0;
    end
    sync_l0_exp = RES_W'(cw_q[4:0]) * RES_W'(ui_q);
  end

  p_valid_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o);
  p_valid_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(adjust_o) && $stable(extra_lat_o) && $stable(ref_lane_o) && $stable(sync_off_o)));
  p_lane0_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !lane0_err_o) |-> (map_q[lane0_lane_o*MAP_W +: MAP_W] == '0 && lane0_first));
  p_err_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (lane0_err_o == !any_zero));
  p_err_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && lane0_err_o) |-> (lane0_lane_o == '0));
  p_ref_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (min_ok && tie_ok));
  p_sync_lane0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sync_off_o[lane0_lane_o*RES_W +: RES_W] == sync_l0_exp));
endmodule

bind fec_ref_lane_calc fec_ref_lane_calc_chk #(
  .LANES(LANES), .MAP_W(MAP_W), .SKEW_W(SKEW_W), .CW_W(CW_W),
  .UI_W(UI_W), .RES_W(RES_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/fec_ref_lane_calc_test.sv
module fec_ref_lane_calc_test;
  localparam int LANES = 4, MAP_W = 7, SKEW_W = 7, CW_W = 15, SM_W = 32;
  localparam int WDLY_W = 20, PMA_W = 16, UI_W = 24, EXT_W = 32, RES_W = 48, IDX_W = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic                    valid_i = 1'b0;
  logic [LANES*MAP_W-1:0]  lane_map_i = '0;
  logic [LANES*SKEW_W-1:0] lane_skew_i = '0;
  logic [CW_W-1:0]         cw_pos_i = '0;
  logic [SM_W-1:0]         const_dly_i = '0;
  logic [LANES*SM_W-1:0]   pulse_off_i = '0;
  logic [LANES*WDLY_W-1:0] wire_dly_i = '0;
  logic [PMA_W-1:0]        pma_dly_i = '0;
  logic [EXT_W-1:0]        ext_dly_i = '0;
  logic [UI_W-1:0]         ui_i = '0;
  logic                    valid_o, lane0_err_o;
  logic [IDX_W-1:0]        ref_lane_o, lane0_lane_o;
  logic [LANES*RES_W-1:0]  sync_off_o;
  logic [RES_W-1:0]        adjust_o, extra_lat_o;

  fec_ref_lane_calc uut (.*);

  int errs = 0, checks = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]};
  endfunction

  function automatic longint sm(logic [31:0] v);
    return v[31] ? -longint'(v[30:0]) : longint'(v[30:0]);
  endfunction

  function automatic longint s48(logic [RES_W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  int map[LANES], skw[LANES], wd[LANES];
  logic [31:0] po[LANES];
  longint sync_e[LANES];

  task automatic run_vec(int i);
    int lane0, refl, err;
    longint adj, ext;
    logic [RES_W-1:0] adj_keep;
    for (int l = 0; l < LANES; l++) begin
      skw[l] = int'(rnd() % 128);
      wd[l]  = int'(rnd() & 32'hFFFFF);
      po[l]  = rnd();
    end
    case (i % 6)
      0: for (int l = 0; l < LANES; l++) map[l] = (l + i) % LANES;
      1: for (int l = 0; l < LANES; l++) map[l] = (LANES - 1 - l + i) % LANES;
      2: for (int l = 0; l < LANES; l++) map[l] = 1 + int'(rnd() % 127);
      3: begin map[0] = 5; map[1] = 0; map[2] = 9; map[3] = 0; end
      4: begin
        for (int l = 0; l < LANES; l++) map[l] = (l + 2) % LANES;
        for (int l = 0; l < LANES; l++) skw[l] = 42;
      end
      default: begin
        for (int l = 0; l < LANES; l++) map[l] = (l + 3) % LANES;
        skw[0] = 90; skw[1] = 70; skw[2] = 3; skw[3] = 3;
      end
    endcase
    cw_pos_i    = 15'(rnd());
    const_dly_i = (i % 7 == 0) ? 32'h8000_0000 : rnd();
    if (i % 5 == 0) po[i % LANES] = 32'h8000_0000;
    pma_dly_i   = 16'(rnd());
    ext_dly_i   = rnd();
    ui_i        = 24'(rnd());
    // extreme corner: max skew spread, full-scale UI and PMA delay
    if (i % 10 == 9) begin
      for (int l = 0; l < LANES; l++) begin
        map[l] = (l + 1) % LANES;
        skw[l] = (map[l] == 0) ? 127 : 0;
      end
      skw[LANES-1] = 127;
      ui_i = 24'hFF_FFFF; pma_dly_i = 16'hFFFF; cw_pos_i = 15'h7FFF;
    end

    lane0 = 0; err = 1;
    for (int l = LANES - 1; l >= 0; l--) if (map[l] == 0) begin lane0 = l; err = 0; end
    refl = 0;
    for (int l = 1; l < LANES; l++) if (skw[l] < skw[refl]) refl = l;
    for (int l = 0; l < LANES; l++)
      sync_e[l] = (longint'(skw[lane0] - skw[l]) * 80 + longint'(cw_pos_i & 15'h1F)) * longint'(ui_i);
    adj = sm(const_dly_i) + sm(po[refl]) - longint'(wd[refl]) + sync_e[refl];
    ext = longint'($signed(ext_dly_i));

    @(negedge clk_i);
    for (int l = 0; l < LANES; l++) begin
      lane_map_i[l*MAP_W +: MAP_W]    = MAP_W'(map[l]);
      lane_skew_i[l*SKEW_W +: SKEW_W] = SKEW_W'(skw[l]);
      wire_dly_i[l*WDLY_W +: WDLY_W]  = WDLY_W'(wd[l]);
      pulse_off_i[l*SM_W +: SM_W]     = po[l];
    end
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R8 valid_o after capture", longint'(valid_o), 1);
    chk("R1 lane0 index", longint'(lane0_lane_o), lane0);
    chk("R2 lane0 error flag", longint'(lane0_err_o), err);
    chk("R4 reference lane", longint'(ref_lane_o), refl);
    for (int l = 0; l < LANES; l++)
      chk("R3 sync offset", s48(sync_off_o[l*RES_W +: RES_W]), sync_e[l]);
    chk("R5 R6 adjust", s48(adjust_o), adj);
    chk("R7 extra latency", s48(extra_lat_o),
        adj - longint'(pma_dly_i) * longint'(ui_i) - ext);
    // change inputs without valid: results must hold
    adj_keep = adjust_o;
    lane_skew_i = ~lane_skew_i;
    const_dly_i = ~const_dly_i;
    cw_pos_i    = ~cw_pos_i;
    @(negedge clk_i);
    chk("R8 valid_o idle", longint'(valid_o), 0);
    chk("R8 adjust hold", s48(adjust_o), s48(adj_keep));
  endtask

  initial begin
    #23;
    chk("R9 reset valid", longint'(valid_o), 0);
    chk("R9 reset adjust", s48(adjust_o), 0);
    chk("R9 reset extra", s48(extra_lat_o), 0);
    chk("R9 reset ref lane", longint'(ref_lane_o), 0);
    chk("R9 reset sync", longint'(sync_off_o == '0), 1);
    rst_ni = 1'b1;
    // R3: upper codeword bits only, all skews equal -> sync = 0
    @(negedge clk_i);
    lane_map_i = {7'd3, 7'd2, 7'd1, 7'd0};
    lane_skew_i = {4{7'd10}};
    cw_pos_i = 15'h7FE0;
    ui_i = 24'd1000;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R3 upper cw bits ignored", longint'(sync_off_o == '0), 1);
    for (int i = 0; i < 240; i++) run_vec(i);
    finish_run();
  end
endmodule